// File: doc/BRIEF.md
# Interrupt Register Bank

This block holds the interrupt control registers of one peripheral with up to one data word of interrupt sources. Each source has a pending flag, a mask bit and a software injection path. Hardware event inputs raise pending flags. Software clears them by writing ones. Software can also raise them through a write-only injection register, which acts exactly as a hardware event would. Each interrupt output pin is its pending flag ANDed with its mask bit.

Software reaches the three registers through a plain single-cycle read/write port that carries a word address. A write takes effect at the clock edge that samples it. A read returns its data one cycle later, with a valid strobe. The block does no bus protocol decoding and has no handshake.

Each source bit is a two-state machine with states IDLE (not pending) and PENDING. The transition SET goes from IDLE to PENDING on a hardware event or an injection write. The transition CLEAR goes from PENDING to IDLE on a write of one to the pending register when no set arrives in the same cycle. The transition HOLD keeps the current state in every other case.

Top module: `irq_regbank`

## Requirements
- R1: After reset, every pending flag, every mask bit, every `irq_o` pin, `rd_data` and `rd_valid` are zero.
- R2: A write to word address 2 (the injection register) ORs the written bits into the pending flags at the next clock edge. Bits written as zero leave their flags unchanged.
- R3: A write to word address 0 (the pending register) clears every flag written as one at the next clock edge. Bits written as zero leave their flags unchanged. After all flags are cleared, every `irq_o` pin is zero.
- R4: A high `hw_event[i]` bit on any clock edge sets pending flag i.
- R5: When a set (a hardware event or an injection) and a clear hit the same flag on the same edge, the flag ends up set.
- R6: `irq_o[i]` equals pending flag i ANDed with mask bit i. A flag can be set and read back while its mask bit is zero.
- R7: Word address 1 (the mask register) is read/write. A write replaces all mask bits, so a read-modify-write changes a single bit and leaves the others as they were.
- R8: Reading the injection register returns zero. Bits at position NUM_IRQ and above read as zero, and writes to them have no effect. Word address 3 reads as zero and ignores writes.
- R9: A read request sampled on a clock edge drives `rd_valid` high for one cycle after that edge. `rd_data` then holds the register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_event | input | NUM_IRQ | Hardware event per source, sampled every edge |
| acc_en | input | 1 | Register access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address: 0 pending, 1 mask, 2 inject |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| irq_o | output | NUM_IRQ | Interrupt pins |

## Verification
A write, an injection or a hardware event takes one edge to reach a pending flag or mask bit. The interrupt pins follow that flag with no further register, so pin checks sample at the falling edge right after the edge that took the stimulus. Read data is due exactly one edge after the request. The driver pushes the expected word into a queue when it issues the read, and the monitor pops and compares that entry at the next falling edge on which `rd_valid` is high. A missing or extra response shows up as a queue mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        SEL_PEND   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_INJECT = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } src_state_e;

endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              wr_pend,
    output logic              wr_mask,
    output logic              wr_inject,
    output logic              rd_req,
    output reg_sel_e          rd_sel
);
    reg_sel_e sel;

    always_comb begin
        if (acc_addr > ADDR_W'(2)) begin
            sel = SEL_NONE;
        end else begin
            sel = reg_sel_e'(acc_addr[1:0]);
        end
    end

    assign wr_pend   = acc_en && acc_we && (sel == SEL_PEND);
    assign wr_mask   = acc_en && acc_we && (sel == SEL_MASK);
    assign wr_inject = acc_en && acc_we && (sel == SEL_INJECT);
    assign rd_req    = acc_en && !acc_we;
    assign rd_sel    = sel;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic mask_wr,
    input  logic mask_bit,
    output logic pend,
    output logic mask,
    output logic pin
);
    src_state_e state_q, state_d;
    logic       mask_q;
    logic       set_any;

    assign set_any = hw_set || sw_set;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (set_any) state_d = ST_PENDING;
            ST_PENDING: if (sw_clr && !set_any) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (mask_wr) begin
            mask_q <= mask_bit;
        end
    end

    assign pend = (state_q == ST_PENDING);
    assign mask = mask_q;
    assign pin  = pend && mask_q;
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  reg_sel_e           rd_sel,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] mask,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid
);
    logic [NUM_IRQ-1:0] pick;

    always_comb begin
        unique case (rd_sel)
            SEL_PEND: pick = pend;
            SEL_MASK: pick = mask;
            default:  pick = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= DATA_W'(pick);
            end
        end
    end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] hw_event,
    input  logic               acc_en,
    input  logic               acc_we,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic [NUM_IRQ-1:0] irq_o
);
    logic               wr_pend, wr_mask, wr_inject, rd_req;
    reg_sel_e           rd_sel;
    logic [NUM_IRQ-1:0] pend_vec, mask_vec;
    logic [NUM_IRQ-1:0] wbits;

    assign wbits = acc_wdata[NUM_IRQ-1:0];

    generate
        if (DATA_W > NUM_IRQ) begin : g_upper
            logic unused_upper;
            assign unused_upper = ^acc_wdata[DATA_W-1:NUM_IRQ];
        end
    endgenerate

    irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .wr_pend  (wr_pend),
        .wr_mask  (wr_mask),
        .wr_inject(wr_inject),
        .rd_req   (rd_req),
        .rd_sel   (rd_sel)
    );

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
            irq_src_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .hw_set  (hw_event[i]),
                .sw_set  (wr_inject && wbits[i]),
                .sw_clr  (wr_pend && wbits[i]),
                .mask_wr (wr_mask),
                .mask_bit(wbits[i]),
                .pend    (pend_vec[i]),
                .mask    (mask_vec[i]),
                .pin     (irq_o[i])
            );
        end
    endgenerate

    irq_read_port #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_sel  (rd_sel),
        .pend    (pend_vec),
        .mask    (mask_vec),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
    parameter int NUM_IRQ = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] hw_event,
    input logic               acc_en,
    input logic               acc_we,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic               rd_valid,
    input logic [NUM_IRQ-1:0] irq_o,
    input logic [NUM_IRQ-1:0] pend_vec,
    input logic [NUM_IRQ-1:0] mask_vec
);
    logic               wr_inj, wr_clr, wr_msk;
    logic [NUM_IRQ-1:0] wb;

    assign wb     = acc_wdata[NUM_IRQ-1:0];
    assign wr_inj = acc_en && acc_we && (acc_addr == ADDR_W'(2));
    assign wr_clr = acc_en && acc_we && (acc_addr == ADDR_W'(0));
    assign wr_msk = acc_en && acc_we && (acc_addr == ADDR_W'(1));

    AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inj |=> ((pend_vec & $past(wb)) == $past(wb)));                       // R2

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pend_vec & $past(wb & ~hw_event)) == '0));                  // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_event) |=> ((pend_vec & $past(hw_event)) == $past(hw_event)));     // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && (|(hw_event & wb))) |=> ((pend_vec & $past(hw_event & wb)) == $past(hw_event & wb))); // R5

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~mask_vec) == '0) && ((irq_o & ~pend_vec) == '0));            // R6

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_msk |=> $stable(mask_vec));                                          // R7

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_valid);                                       // R9
endmodule

bind irq_regbank irq_regbank_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_event (hw_event),
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .rd_valid (rd_valid),
    .irq_o    (irq_o),
    .pend_vec (pend_vec),
    .mask_vec (mask_vec)
);

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;
    localparam int N  = 8;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw_event = '0;
    logic          acc_en = 1'b0, acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0]  m_pend = '0, m_mask = '0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    irq_regbank #(.NUM_IRQ(N), .DATA_W(DW), .ADDR_W(AW)) u_irq_regbank (
        .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read words as responses arrive
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected response", rd_data, 32'hDEAD_BEEF);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [N-1:0] ev);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d; hw_event = ev;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0; hw_event = '0;
        case (a)
            0: m_pend = (m_pend & ~d[N-1:0]) | ev;
            1: begin m_mask = d[N-1:0]; m_pend = m_pend | ev; end
            2: m_pend = m_pend | d[N-1:0] | ev;
            default: m_pend = m_pend | ev;
        endcase
    endtask

    task automatic event_pulse(input logic [N-1:0] ev);
        @(negedge clk);
        hw_event = ev;
        @(negedge clk);
        hw_event = '0;
        m_pend = m_pend | ev;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic pins(input string tag);
        check(tag, DW'(irq_o), DW'(m_pend & m_mask));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pins after reset", DW'(irq_o), '0);
        check("R1 rd_valid after reset", DW'(rd_valid), '0);
        check("R1 rd_data after reset", rd_data, '0);
        rst_n = 1'b1;
        rd(0, 0, "R1 pending reads zero");
        rd(1, 0, "R1 mask reads zero");

        wr(1, 32'h0F, '0);
        rd(1, 32'h0F, "R7 mask readback");

        wr(2, 32'h81, '0);
        pins("R6 pins after inject");
        rd(0, 32'h81, "R9 R2 inject visible one cycle later");
        wr(2, 32'h02, '0);
        rd(0, 32'h83, "R2 zeros in inject keep flags");

        wr(0, 32'h01, '0);
        pins("R3 pins after clear");
        rd(0, 32'h82, "R3 clear only ones");

        event_pulse(8'h10);
        pins("R6 masked event has no pin");
        rd(0, 32'h92, "R4 hw event sets flag, R6 readable while masked");

        wr(0, 32'h02, 8'h02);
        rd(0, 32'h92, "R5 set wins over clear");
        pins("R5 pin stays up");

        wr(1, 32'h0F | 32'h10, '0);
        rd(1, 32'h1F, "R7 read-modify-write adds one bit");
        pins("R6 pin after unmask");

        rd(2, 0, "R8 inject reads zero");
        wr(1, 32'hFFFF_FF00 | 32'h1F, '0);
        rd(1, 32'h1F, "R8 upper mask bits ignored");
        wr(3, 32'hFF, '0);
        rd(0, 32'h92, "R8 unmapped write ignored");
        rd(3, 0, "R8 unmapped reads zero");

        wr(0, 32'hFF, '0);
        check("R3 pins zero after full clear", DW'(irq_o), '0);
        rd(0, 0, "R3 pending empty");

        repeat (3) @(negedge clk);
        check("R9 all responses arrived", DW'(exp_q.size()), '0);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule